// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block lives inside a single-rank SDR SDRAM controller. It puts the memory into its low-power self-refresh state and brings it back out. A sleep request from the system moves the memory into self refresh once every bank is precharged. A wake request brings it out through a fixed exit sequence. While the sequencer is busy it owns the command lines (chip select, row strobe, column strobe, write enable) and the clock-enable pin.

Entry takes one cycle. The sequencer drives the auto-refresh command encoding and pulls clock enable low in that same cycle. Clock enable then stays low for at least `TRAS_CYC` cycles. The exit path works in order: it waits for the system to report a stable clock, raises clock enable, and then holds a NOP-only window. This window lasts `TXSR_CYC` cycles, and never less than two. When the window ends, a one-cycle `done` pulse tells the refresh scheduler that it may restart periodic auto refresh and let normal traffic through.

Top module: `sr_seq`

## Requirements
- R1: After reset, `cke` is high, the command lines carry NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1), and `busy` and `done` are low.
- R2: In the single entry cycle the command lines carry the refresh encoding (`cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1) and `cke` falls in that same cycle. In every other cycle they carry NOP.
- R3: A `sleep_req` seen in idle while `banks_idle` is low is held pending. Entry starts in the cycle after the first clock edge at which `banks_idle` is high. With `banks_idle` already high, entry starts in the cycle after the request edge.
- R4: Once entry is issued, `cke` stays low without a break until exit. It stays low for at least `TRAS_CYC` cycles.
- R5: A `wake_req` that arrives during entry, or before the minimum self-refresh time is over, is remembered. Exit begins as soon as the minimum time has expired.
- R6: `cke` rises only in the cycle after an edge at which `clk_stable` was high. Until then the sequencer waits with `cke` low.
- R7: Starting with the cycle in which `cke` rises, NOP is issued with `cke` high for exactly max(`TXSR_CYC`, 2) cycles.
- R8: In the cycle after that window, `done` is high for exactly one cycle. The sequencer is idle in the cycle after that.
- R9: `busy` is high from the entry cycle up to and including the `done` cycle, and low otherwise.
- R10: A `sleep_req` that arrives while the sequencer is busy is dropped, so no new entry follows `done`. A `wake_req` that arrives while idle is dropped and does not shorten a later sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter self refresh |
| wake_req | input | 1 | Request to leave self refresh |
| banks_idle | input | 1 | All banks precharged |
| clk_stable | input | 1 | Clock reported stable for wake-up |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| busy | output | 1 | Sequencer holds the command bus |
| done | output | 1 | One-cycle pulse: scheduler may resume refresh |

## Verification
Each sleep and wake cycle varies four things: how long `banks_idle` stays low after the request, when the wake request arrives relative to the minimum-time expiry, when `clk_stable` rises relative to the exit point, and where a stray sleep request lands inside the busy period. An early wake separates a design that latches the request from one that drops it. A late wake checks that exit follows the request and not the timer. A late clock-stable signal shows that the rise of `cke` is gated, and an early one shows that no extra wait is added. Two instances, one with a long NOP window and one whose parameter is below two, check that the window length is forced up to the two-cycle floor.

// File: rtl/sr_seq.sv
module sr_seq #(
  parameter int TRAS_CYC = 6,
  parameter int TXSR_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic banks_idle,
  input  logic clk_stable,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic busy,
  output logic done
);
  localparam int NOP_CYC = (TXSR_CYC < 2) ? 2 : TXSR_CYC;
  localparam int CNT_MAX = (TRAS_CYC > NOP_CYC) ? TRAS_CYC : NOP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ENTER, S_IN_SR, S_WAIT_CLK, S_CKE_HIGH, S_XSR_NOP, S_DONE
  } st_t;

  st_t              st, st_nx;
  logic [CNT_W-1:0] cnt;
  logic             sleep_pend, wake_lat;
  logic             go_sleep, go_wake;

  assign go_sleep = (sleep_req | sleep_pend) & banks_idle;
  assign go_wake  = (st == S_IN_SR) && (cnt == '0) && (wake_req | wake_lat);

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:     if (go_sleep) st_nx = S_ENTER;
      S_ENTER:    st_nx = S_IN_SR;
      S_IN_SR:    if (go_wake) st_nx = S_WAIT_CLK;
      S_WAIT_CLK: if (clk_stable) st_nx = S_CKE_HIGH;
      S_CKE_HIGH: st_nx = S_XSR_NOP;
      S_XSR_NOP:  if (cnt == '0) st_nx = S_DONE;
      S_DONE:     st_nx = S_IDLE;
      default:    st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      sleep_pend <= 1'b0;
      wake_lat   <= 1'b0;
    end else begin
      st <= st_nx;

      if (st == S_IDLE)
        sleep_pend <= (sleep_req | sleep_pend) & ~banks_idle;
      else
        sleep_pend <= 1'b0;

      if (st == S_ENTER || st == S_IN_SR)
        wake_lat <= (wake_req | wake_lat) & ~go_wake;
      else
        wake_lat <= 1'b0;

      case (st)
        S_ENTER:    cnt <= CNT_W'(TRAS_CYC - 1);
        S_CKE_HIGH: cnt <= CNT_W'(NOP_CYC - 2);
        S_IN_SR, S_XSR_NOP: if (cnt != '0) cnt <= cnt - 1'b1;
        default:    cnt <= cnt;
      endcase
    end
  end

  wire entry = (st == S_ENTER);

  assign cke   = ~(entry || st == S_IN_SR || st == S_WAIT_CLK);
  assign cs_n  = 1'b0;
  assign ras_n = ~entry;
  assign cas_n = ~entry;
  assign we_n  = 1'b1;
  assign busy  = (st != S_IDLE);
  assign done  = (st == S_DONE);
endmodule

// File: rtl/sr_seq_chk.sv
module sr_seq_chk #(
  parameter int TRAS_CYC = 6,
  parameter int TXSR_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic clk_stable,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic busy,
  input logic done
);
  localparam int NOP_CYC = (TXSR_CYC < 2) ? 2 : TXSR_CYC;

  logic        cke_q;
  logic [15:0] low_cnt;
  logic [15:0] win;
  wire         is_nop  = !cs_n && ras_n && cas_n && we_n;
  wire         is_ref  = !cs_n && !ras_n && !cas_n && we_n;
  wire         cke_up  = cke && !cke_q;
  wire         cke_dn  = !cke && cke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q   <= 1'b1;
      low_cnt <= '0;
      win     <= '0;
    end else begin
      cke_q <= cke;
      if (!cke) low_cnt <= (low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 16'd1;
      else      low_cnt <= '0;
      if (cke_up)        win <= 16'(NOP_CYC - 1);
      else if (win != 0) win <= win - 16'd1;
    end
  end

  AST_ENTRY_IS_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    cke_dn |-> is_ref);                                                  // R2
  AST_MIN_SR_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    cke_up |-> (low_cnt >= 16'(TRAS_CYC)));                              // R4
  AST_CLK_STABLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cke_up |-> $past(clk_stable));                                       // R6
  AST_NOP_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cke_up |-> is_nop);                                                  // R7
  AST_NOP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (win != 0) |-> (is_nop && cke && !done));                            // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                     // R8
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);                                                     // R8
  AST_BUSY_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> busy);                                                      // R9
endmodule

bind sr_seq sr_seq_chk #(.TRAS_CYC(TRAS_CYC), .TXSR_CYC(TXSR_CYC)) u_chk (.*);

// File: tb/test_sr_seq.sv
module test_sr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TRAS  = 5;
  localparam int TXSR0 = 4;
  localparam int TXSR1 = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 0, wake_req = 0, banks_idle = 0, clk_stable = 0;
  logic [1:0] cke, cs_n, ras_n, cas_n, we_n, busy, done;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_seq #(.TRAS_CYC(TRAS), .TXSR_CYC(TXSR0)) i_sr_seq (
    .clk, .rst_n, .sleep_req, .wake_req, .banks_idle, .clk_stable,
    .cke(cke[0]), .cs_n(cs_n[0]), .ras_n(ras_n[0]), .cas_n(cas_n[0]),
    .we_n(we_n[0]), .busy(busy[0]), .done(done[0]));

  sr_seq #(.TRAS_CYC(TRAS), .TXSR_CYC(TXSR1)) i_sr_seq_min (
    .clk, .rst_n, .sleep_req, .wake_req, .banks_idle, .clk_stable,
    .cke(cke[1]), .cs_n(cs_n[1]), .ras_n(ras_n[1]), .cas_n(cas_n[1]),
    .we_n(we_n[1]), .busy(busy[1]), .done(done[1]));

  function automatic int nops(int d);
    int t = (d == 0) ? TXSR0 : TXSR1;
    return (t < 2) ? 2 : t;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Scenario: k counts clock edges from the start; inputs for edge k are
  // driven at the negedge before it, outputs after edge j are sampled there too.
  task automatic scen(int b, int w, int s, int x);
    int kw = imax(b + TRAS + 1, w);
    int kc = imax(kw + 1, s);
    int last = kc + nops(0) + 6;
    for (int k = 0; k <= last + 1; k++) begin
      @(negedge clk);
      if (k > 0) begin
        int j = k - 1;
        for (int d = 0; d < 2; d++) begin
          int kd = kc + nops(d);
          bit e_cke  = !(j >= b && j < kc);
          bit e_ent  = (j == b);
          bit e_busy = (j >= b && j <= kd);
          string tc;
          int cmd_a = {cs_n[d], ras_n[d], cas_n[d], we_n[d]};
          int cmd_e = e_ent ? 4'b0001 : 4'b0111;
          if (j < b)           tc = "R3";
          else if (j < kc - 1) tc = "R4";
          else if (j == kc - 1 || j == kc) tc = (w <= b + TRAS) ? "R5" : "R6";
          else if (j > kd)     tc = "R10";
          else                 tc = "R7";
          chk(cke[d] == e_cke, tc, $sformatf("cke dut%0d j%0d", d, j), cke[d], e_cke);
          chk(cmd_a == cmd_e, (j >= kc && j < kd) ? "R7" : "R2",
              $sformatf("cmd dut%0d j%0d", d, j), cmd_a, cmd_e);
          chk(busy[d] == e_busy, "R9", $sformatf("busy dut%0d j%0d", d, j), busy[d], e_busy);
          chk(done[d] == (j == kd), "R8", $sformatf("done dut%0d j%0d", d, j), done[d], j == kd);
        end
      end
      sleep_req  = (k == 0) || (k == x);
      wake_req   = (k == w) || (k == 0 && b > 0);
      banks_idle = (k >= b);
      clk_stable = (k >= s);
    end
    sleep_req = 0; wake_req = 0; banks_idle = 0; clk_stable = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int d = 0; d < 2; d++) begin
      chk(cke[d] == 1'b1, "R1", "cke in reset", cke[d], 1);
      chk({cs_n[d], ras_n[d], cas_n[d], we_n[d]} == 4'b0111, "R1", "cmd in reset",
          {cs_n[d], ras_n[d], cas_n[d], we_n[d]}, 4'b0111);
      chk(busy[d] == 1'b0 && done[d] == 1'b0, "R1", "busy/done in reset",
          {busy[d], done[d]}, 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    scen(0, 1, 0, 3);                     // R5 earliest wake, stable clock already
    scen(3, 4, 0, 5);                     // R3 pending sleep, R5 wake during entry
    scen(0, TRAS + 9, 0, 2);              // R6 late wake drives exit
    scen(2, 4, TRAS + 14, 7);             // R6 late clock-stable gating
    scen(0, TRAS + 1, TRAS + 2, 1);       // exit exactly at expiry
    for (int n = 0; n < 30; n++) begin
      int b = $urandom_range(0, 5);
      int w = b + 1 + $urandom_range(0, TRAS + 6);
      int s = $urandom_range(0, b + TRAS + 12);
      int x = b + 1 + $urandom_range(0, TRAS);
      scen(b, w, s, x);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule